// File: doc/BRIEF.md
# DRAM Read Access Sequencer

This block times DRAM read cycles for a 16-bit CPU with an asynchronous bus. When the CPU starts a read cycle into the RAM address window, the block asserts a RAM enable, then the row strobe, then moves the DRAM address multiplexer from row bits to column bits. It asserts one column strobe per byte lane, each only for the lanes whose data strobe is active. The returning DRAM word passes through a transparent latch. The latch closes at a fixed system phase and keeps the word on the CPU data bus after the short RAM cycle has ended, until the CPU drops both data strobes.

All timing comes from three system phase clocks (`ph1`, `ph3`, `ph4`). The fast clock `clk` samples them, and every output is a register. The DRAM row address is CPU address bits A1 upward (`cpu_addr[ROW_W-1:0]`), and the column address is the next `ROW_W` bits. The upper address bits above both halves select the window.

Top module: `dram_rd_seq`

## Requirements
- R1: `ram_en_n` falls at the first clock edge that samples all of these: `as_n`=0, `rw`=1, `cpu_addr[ADDR_W-1:2*ROW_W]`==`WIN_TAG`, `ph1`=1 and `ph3`=0. It stays low until the edge after the one that samples `as_n`=1.
- R2: `dram_addr` is a register. It holds `cpu_addr[ROW_W-1:0]` whenever `mux_col` is 0 and `cpu_addr[2*ROW_W-1:ROW_W]` whenever `mux_col` is 1.
- R3: `ras_n` falls one clock after `ram_en_n` falls, and it rises at the same edge as `ram_en_n`.
- R4: `mux_col` rises one clock after `ras_n` falls and clears together with `ras_n`.
- R5: The upper column strobe `cas_hi_n` asserts only while `uds_n`=0, and the lower strobe `cas_lo_n` asserts only while `lds_n`=0. A lane whose data strobe is high keeps its column strobe high.
- R6: A column strobe falls at the first edge that samples `mux_col`=1 and `ph1`=0 with its data strobe low. It then stays low until the edge after the one that samples `as_n`=1.
- R7: While `rd_n` is low, `cpu_data` follows `dram_dq` with one clock of delay. At the first edge that samples a low column strobe together with `ph1`=0 and `ph4`=0, the latch captures `dram_dq` and then holds it, even if `dram_dq` changes later.
- R8: `rd_n` falls one clock after `ram_en_n` falls. It rises one clock after an edge that samples both `uds_n` and `lds_n` high, and not while either of them is still low. `cpu_data` is valid only while `rd_n`=0.
- R9: A cycle with `rw`=0, or with an address outside the window, asserts none of `ram_en_n`, `ras_n`, `cas_hi_n`, `cas_lo_n` and `rd_n`.
- R10: During reset, all active-low outputs are 1, `mux_col` is 0, and `cpu_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | CPU address strobe, active low |
| uds_n | input | 1 | CPU upper data strobe, active low |
| lds_n | input | 1 | CPU lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | ADDR_W | CPU word address; bit 0 is A1 |
| ph1 | input | 1 | Phase clock 1 |
| ph3 | input | 1 | Phase clock 3 |
| ph4 | input | 1 | Phase clock 4 |
| dram_dq | input | DATA_W | Data from the DRAM array |
| ram_en_n | output | 1 | RAM enable, active low |
| ras_n | output | 1 | Row strobe, active low |
| mux_col | output | 1 | Address mux select: 0 = row, 1 = column |
| cas_hi_n | output | 1 | Upper lane column strobe, active low |
| cas_lo_n | output | 1 | Lower lane column strobe, active low |
| dram_addr | output | ROW_W | Multiplexed DRAM address |
| rd_n | output | 1 | CPU data read strobe and bus drive enable, active low |
| cpu_data | output | DATA_W | Latched read data for the CPU bus |

## Verification
The bench builds the block with `ADDR_W`=20 and `WIN_TAG`=3, so a 4-bit window compare is live, and addresses in tag 5 exercise the miss path. It keeps `ROW_W`=8 and `DATA_W`=16, so row and column each use a full byte. Because the DRAM stub returns `{row, column}`, the final latched word shows directly whether the multiplexer, the lane strobes and the latch close point were ordered correctly. The phase clocks run on an 8-cycle pattern, so bus cycles that start in the `ph3`-high part of the pattern test the wait for the start window.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;
   localparam int LANES = 2;
   localparam int LANE_HI = 1;
   localparam int LANE_LO = 0;
   typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/drs_decode.sv
module drs_decode #(
   parameter int ADDR_W = 23,
   parameter int ROW_W  = 8,
   parameter int WIN_TAG = 0
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              as_n,
   input  logic              rw,
   input  logic              ph1,
   input  logic              ph3,
   output logic              start
);
   localparam int TAG_LSB = 2 * ROW_W;
   localparam int TAG_W   = ADDR_W - TAG_LSB;

   logic in_win;

   generate
      if (TAG_W < 1) begin : g_bad
         $error("drs_decode: ADDR_W must exceed 2*ROW_W");
      end
   endgenerate

   assign in_win = (cpu_addr[ADDR_W-1:TAG_LSB] == TAG_W'(WIN_TAG));
   assign start  = !as_n && rw && in_win && ph1 && !ph3;
endmodule

// File: rtl/drs_timing.sv
module drs_timing
   import dram_rd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      as_n,
   input  logic      start,
   input  logic      ph1,
   input  lane_vec_t strb_n,
   output logic      ram_en_n,
   output logic      ras_n,
   output logic      mux_col,
   output logic      mux_col_nxt,
   output lane_vec_t cas_n
);
   logic ram_en_d, ras_d;

   assign ram_en_d    = as_n ? 1'b1 : (start ? 1'b0 : ram_en_n);
   assign ras_d       = as_n ? 1'b1 : ram_en_n;
   assign mux_col_nxt = !as_n && !ras_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_en_n <= 1'b1;
         ras_n    <= 1'b1;
         mux_col  <= 1'b0;
      end else begin
         ram_en_n <= ram_en_d;
         ras_n    <= ras_d;
         mux_col  <= mux_col_nxt;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic cas_d;
      assign cas_d = as_n ? 1'b1 : (cas_n[i] & ~(mux_col & ~ph1 & ~strb_n[i]));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cas_n[i] <= 1'b1;
         else        cas_n[i] <= cas_d;
      end

      AST_CAS_NEEDS_COL: assert property (@(posedge clk) disable iff (!rst_n)
         !cas_n[i] |-> mux_col);                                    // R6
      AST_CAS_LANE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(cas_n[i]) |-> $past(!strb_n[i]));                    // R5
   end

   AST_RAS_UNDER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !ram_en_n);                                        // R3
   AST_START_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_en_n) |-> $past(start));                            // R1
   AST_COL_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mux_col) |-> $past(!ras_n));                            // R4
endmodule

// File: rtl/drs_addr_mux.sv
module drs_addr_mux #(
   parameter int ADDR_W = 23,
   parameter int ROW_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              col_sel,
   output logic [ROW_W-1:0]  dram_addr
);
   logic [ROW_W-1:0] row_part, col_part;

   assign row_part = cpu_addr[ROW_W-1:0];
   assign col_part = cpu_addr[2*ROW_W-1:ROW_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dram_addr <= '0;
      else        dram_addr <= col_sel ? col_part : row_part;
   end
endmodule

// File: rtl/drs_rd_latch.sv
module drs_rd_latch
   import dram_rd_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ram_en_n,
   input  lane_vec_t         strb_n,
   input  lane_vec_t         cas_n,
   input  logic              ph1,
   input  logic              ph4,
   input  logic [DATA_W-1:0] dram_dq,
   output logic              rd_n,
   output logic [DATA_W-1:0] cpu_data
);
   logic strb_off, held, held_d, rd_d, close_now;

   generate
      if (DATA_W % LANES != 0) begin : g_bad
         $error("drs_rd_latch: DATA_W must split evenly into byte lanes");
      end
   endgenerate

   assign strb_off  = &strb_n;
   assign close_now = ~&cas_n & ~ph1 & ~ph4;
   assign rd_d      = strb_off ? 1'b1 : (ram_en_n ? rd_n : 1'b0);
   assign held_d    = strb_off ? 1'b0 : (held | close_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_n     <= 1'b1;
         held     <= 1'b0;
         cpu_data <= '0;
      end else begin
         rd_n <= rd_d;
         held <= held_d;
         if (!rd_n && !held) cpu_data <= dram_dq;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(held) && held) |-> $stable(cpu_data));                 // R7
   AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(strb_off) |-> rd_n);                                    // R8
   AST_RD_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> $past(!ram_en_n));                            // R8
endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq
   import dram_rd_pkg::*;
#(
   parameter int ADDR_W  = 23,
   parameter int ROW_W   = 8,
   parameter int DATA_W  = 16,
   parameter int WIN_TAG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_n,
   input  logic              uds_n,
   input  logic              lds_n,
   input  logic              rw,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              ph1,
   input  logic              ph3,
   input  logic              ph4,
   input  logic [DATA_W-1:0] dram_dq,
   output logic              ram_en_n,
   output logic              ras_n,
   output logic              mux_col,
   output logic              cas_hi_n,
   output logic              cas_lo_n,
   output logic [ROW_W-1:0]  dram_addr,
   output logic              rd_n,
   output logic [DATA_W-1:0] cpu_data
);
   lane_vec_t strb_n, cas_n;
   logic      start, col_nxt;

   generate
      if (DATA_W != 8 * LANES) begin : g_bad_w
         $error("dram_rd_seq: DATA_W must be one byte per lane");
      end
      if (ROW_W < 1) begin : g_bad_r
         $error("dram_rd_seq: ROW_W must be positive");
      end
   endgenerate

   assign strb_n[LANE_HI] = uds_n;
   assign strb_n[LANE_LO] = lds_n;
   assign cas_hi_n = cas_n[LANE_HI];
   assign cas_lo_n = cas_n[LANE_LO];

   drs_decode #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .WIN_TAG(WIN_TAG)) u_dec (
      .cpu_addr(cpu_addr), .as_n(as_n), .rw(rw), .ph1(ph1), .ph3(ph3),
      .start(start));

   drs_timing u_tim (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .start(start), .ph1(ph1),
      .strb_n(strb_n), .ram_en_n(ram_en_n), .ras_n(ras_n),
      .mux_col(mux_col), .mux_col_nxt(col_nxt), .cas_n(cas_n));

   drs_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .col_sel(col_nxt),
      .dram_addr(dram_addr));

   drs_rd_latch #(.DATA_W(DATA_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .ram_en_n(ram_en_n), .strb_n(strb_n),
      .cas_n(cas_n), .ph1(ph1), .ph4(ph4), .dram_dq(dram_dq),
      .rd_n(rd_n), .cpu_data(cpu_data));

   AST_NO_WRITE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_en_n) |-> $past(rw));                               // R9
   AST_ADDR_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_col && $past(mux_col) && $stable(cpu_addr)) |-> $stable(dram_addr)); // R2
endmodule

// File: tb/tb_dram_rd_seq.sv
module tb_dram_rd_seq;
   localparam int AW = 20, RW = 8, DW = 16, TAG = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] noise = '0;
   logic [RW-1:0] row_q = '0;
   int ph_idx = 0;
   logic ph1, ph3, ph4;
   logic [DW-1:0] dram_dq;
   logic ram_en_n, ras_n, mux_col, cas_hi_n, cas_lo_n, rd_n;
   logic [RW-1:0] dram_addr;
   logic [DW-1:0] cpu_data;
   int checks = 0, failures = 0;

   always #10 clk = ~clk;

   assign ph1 = (ph_idx < 4);
   assign ph3 = (ph_idx >= 2 && ph_idx <= 5);
   assign ph4 = (ph_idx < 6);

   // DRAM stub: row captured while the row strobe is high, word = {row, column}
   always @(negedge clk) if (ras_n) row_q <= dram_addr;
   assign dram_dq = ((!cas_hi_n || !cas_lo_n) ? {row_q, dram_addr} : 16'h5A5A) ^ noise;

   dram_rd_seq #(.ADDR_W(AW), .ROW_W(RW), .DATA_W(DW), .WIN_TAG(TAG)) dut (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
      .rw(rw), .cpu_addr(cpu_addr), .ph1(ph1), .ph3(ph3), .ph4(ph4),
      .dram_dq(dram_dq), .ram_en_n(ram_en_n), .ras_n(ras_n), .mux_col(mux_col),
      .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n), .dram_addr(dram_addr),
      .rd_n(rd_n), .cpu_data(cpu_data));

   // Behavioural reference: activity flags advanced once per clock
   int m_en = 0, m_ras = 0, m_col = 0, m_hi = 0, m_lo = 0, m_rd = 0, m_held = 0;
   logic [DW-1:0] m_data = '0;
   logic [RW-1:0] m_addr = '0;

   always @(posedge clk) begin
      int en0, ras0, col0, hi0, lo0, rd0, held0;
      bit hit;
      en0 = m_en; ras0 = m_ras; col0 = m_col; hi0 = m_hi; lo0 = m_lo;
      rd0 = m_rd; held0 = m_held;
      if (!rst_n) begin
         m_en = 0; m_ras = 0; m_col = 0; m_hi = 0; m_lo = 0;
         m_rd = 0; m_held = 0; m_data = '0; m_addr = '0;
      end else begin
         hit = (cpu_addr[AW-1:16] == TAG) && rw && ph1 && !ph3;
         if (as_n) begin
            m_en = 0; m_ras = 0; m_col = 0; m_hi = 0; m_lo = 0;
         end else begin
            if (en0 == 0 && hit) m_en = 1;
            m_ras = en0;
            m_col = ras0;
            if (col0 == 1 && !ph1 && !uds_n) m_hi = 1;
            if (col0 == 1 && !ph1 && !lds_n) m_lo = 1;
         end
         if (uds_n && lds_n) m_rd = 0;
         else if (en0 == 1) m_rd = 1;
         if (rd0 == 1 && held0 == 0) m_data = dram_dq;
         if (uds_n && lds_n) m_held = 0;
         else if ((hi0 == 1 || lo0 == 1) && !ph1 && !ph4) m_held = 1;
         m_addr = (m_col == 1) ? cpu_addr[15:8] : cpu_addr[7:0];
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp_v, $time);
      end
   endtask

   task automatic cmp_all();
      chk(ram_en_n == (m_en == 0), "R1 ram_en_n", 32'(ram_en_n), 32'(m_en == 0));
      chk(ras_n == (m_ras == 0), "R3 ras_n", 32'(ras_n), 32'(m_ras == 0));
      chk(mux_col == (m_col == 1), "R4 mux_col", 32'(mux_col), 32'(m_col));
      chk(cas_hi_n == (m_hi == 0), "R5 cas_hi_n", 32'(cas_hi_n), 32'(m_hi == 0));
      chk(cas_lo_n == (m_lo == 0), "R6 cas_lo_n", 32'(cas_lo_n), 32'(m_lo == 0));
      chk(dram_addr == m_addr, "R2 dram_addr", 32'(dram_addr), 32'(m_addr));
      chk(rd_n == (m_rd == 0), "R8 rd_n", 32'(rd_n), 32'(m_rd == 0));
      if (m_rd == 1) chk(cpu_data == m_data, "R7 cpu_data", 32'(cpu_data), 32'(m_data));
   endtask

   task automatic step();
      @(negedge clk);
      if (rst_n) cmp_all();
      ph_idx = (ph_idx + 1) % 8;
   endtask

   // One bus cycle. align = phase index at which the address strobe is driven.
   task automatic bus(input logic [AW-1:0] a, input bit u, input bit l,
                      input bit rd, input int align, input bit hit);
      logic [DW-1:0] want;
      want = {a[7:0], a[15:8]};
      while (ph_idx != align) step();
      cpu_addr = a; rw = rd; as_n = 1'b0; uds_n = !u; lds_n = !l;
      if (align == 2) begin
         step(); step();
         chk(ram_en_n == 1'b1, "R1 wait_ph3", 32'(ram_en_n), 32'd1);
      end
      while (ph_idx != 7) step();
      step(); step(); step(); step(); step(); step(); step(); step();
      if (hit) begin
         chk(cpu_data == want, "R7 latched_word", 32'(cpu_data), 32'(want));
         chk(rd_n == 1'b0, "R8 bus_driven", 32'(rd_n), 32'd0);
         chk(cas_hi_n == !u, "R5 hi_lane", 32'(cas_hi_n), 32'(!u));
         chk(cas_lo_n == !l, "R5 lo_lane", 32'(cas_lo_n), 32'(!l));
         noise = 16'hFFFF; step(); step();
         chk(cpu_data == want, "R7 hold_after_close", 32'(cpu_data), 32'(want));
         noise = '0;
      end else begin
         chk({ram_en_n, ras_n, cas_hi_n, cas_lo_n, rd_n} == 5'h1F, "R9 no_access",
             32'({ram_en_n, ras_n, cas_hi_n, cas_lo_n, rd_n}), 32'h1F);
      end
      if (u && l) begin
         uds_n = 1'b1; step(); step();
         chk(rd_n == !hit, "R8 one_strobe_left", 32'(rd_n), 32'(!hit));
      end
      uds_n = 1'b1; lds_n = 1'b1; as_n = 1'b1;
      step(); step();
      chk(rd_n == 1'b1, "R8 released", 32'(rd_n), 32'd1);
      chk(ras_n == 1'b1, "R3 ras_released", 32'(ras_n), 32'd1);
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({ram_en_n, ras_n, cas_hi_n, cas_lo_n, rd_n, mux_col} == 6'b111110, "R10 reset_ctl",
          32'({ram_en_n, ras_n, cas_hi_n, cas_lo_n, rd_n, mux_col}), 32'h3E);
      chk(cpu_data == '0, "R10 reset_data", 32'(cpu_data), 32'd0);
      rst_n = 1'b1;
      bus(20'h3A51C, 1, 1, 1, 0, 1);
      bus(20'h3C3F0, 1, 0, 1, 0, 1);
      bus(20'h30F81, 0, 1, 1, 2, 1);
      bus(20'h31234, 1, 1, 0, 0, 0);
      bus(20'h5A51C, 1, 1, 1, 0, 0);
      bus(20'h3FFFF, 1, 1, 1, 1, 1);
      repeat (4) step();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule